// File: doc/BRIEF.md
# Alternating-Channel Serial ADC Host Controller

This block is the host side of a link to a two-input serial successive-approximation converter. The converter does not take a channel address. Instead it keeps an internal pointer that starts on input 0 after power-up and flips to the other input every time chip-select goes low. The controller keeps a shadow copy of that pointer. It takes a request that names the wanted input. When the next conversion would land on the other input, it first issues a short chip-select pulse with no serial clocks, which moves the converter's pointer on by one.

After any such pulse, the controller runs a full frame. It holds chip-select low through the acquisition clocks and generates the serial clock at a programmable division of the system clock. It samples the data line on rising serial-clock edges. From the frame it takes the channel-identification bit and the twelve data bits. The result goes out over a valid/ready interface with a channel tag and a mismatch flag. When the returned identification bit disagrees with the shadow pointer, the controller sets the flag and realigns the shadow pointer to what the converter reported.

Top module: `adc_alt_host`

## Requirements
- R1: After reset, adcCsN is high, adcSclk is low, resValid is low, busy is low, reqReady is high, and the shadow pointer selects input 0. A first request for input 0 therefore produces exactly one chip-select falling edge.
- R2: A request whose channel equals the shadow pointer produces exactly one chip-select falling edge, which is the frame itself. Requests alternating 0, 1, 0, 1 never insert an extra toggle.
- R3: A request whose channel differs from the shadow pointer produces exactly two chip-select falling edges. The first is a dummy low pulse of CLK_DIV system cycles during which no serial-clock edge occurs.
- R4: Before every falling edge, adcCsN has been high for at least CS_HIGH_MIN system cycles.
- R5: A frame has exactly ACQ_CLKS+1+DATA_W rising serial-clock edges, spaced 2*CLK_DIV system cycles apart. adcCsN stays low from the start of the frame until after the last clock falls, and adcSclk never rises while adcCsN is high.
- R6: Counting rising serial-clock edges of a frame from 1, edge ACQ_CLKS+1 samples the identification bit. Edges ACQ_CLKS+2 to ACQ_CLKS+1+DATA_W sample the result, MSB first, and that result appears on resData.
- R7: resChan equals the sampled identification bit. resMismatch is 1 exactly when that bit differs from the channel the shadow pointer predicted for the frame.
- R8: After a mismatch, the shadow pointer moves to the input after the reported one. A following request for the reported input's successor then needs no dummy toggle.
- R9: resValid stays high, with resData, resChan and resMismatch stable, until resReady is seen high. In the next cycle resValid is low and reqReady is high.
- R10: From the cycle after a request is accepted until the result is taken, busy is high and reqReady is low. A request offered during that time is ignored and starts no further frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Conversion request offered |
| reqChan | input | 1 | Wanted input (0 or 1) |
| reqReady | output | 1 | Controller idle and taking a request |
| adcCsN | output | 1 | Converter chip-select, active low |
| adcSclk | output | 1 | Serial clock to the converter |
| adcSdo | input | 1 | Serial data from the converter |
| resValid | output | 1 | Result available |
| resReady | input | 1 | Consumer takes the result |
| resData | output | DATA_W | Converted value |
| resChan | output | 1 | Identification bit reported by the converter |
| resMismatch | output | 1 | Reported channel differed from the shadow pointer |
| busy | output | 1 | Request in progress or result waiting |

## Verification
The hardest situation to reach is the one where the converter's hidden pointer has drifted away from the controller's shadow copy. A correct controller never causes this drift, so the port traffic alone cannot produce it. The bench's converter model therefore has a hook that flips its own pointer between two requests, as a stray chip-select pulse would. The next frame then returns the unexpected identification bit. The bench checks that the mismatch is flagged, and then checks that the request after it needs no dummy toggle, which shows the shadow pointer realigned.

// File: rtl/adc_host_pkg.sv
`timescale 1ns/1ps
package adc_host_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CSHI,
    ST_DUMLO,
    ST_LOW,
    ST_HIGH,
    ST_DONE
  } hostState_t;

  typedef struct packed {
    logic dummyFall;
    logic frameStart;
    logic sampleBit;
    logic frameEnd;
  } hostStrb_t;

endpackage

// File: rtl/adc_host_ctrl.sv
`timescale 1ns/1ps
module adc_host_ctrl
  import adc_host_pkg::*;
#(
  parameter int DATA_W      = 12,
  parameter int ACQ_CLKS    = 2,
  parameter int CLK_DIV     = 4,
  parameter int CS_HIGH_MIN = 8
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqValid,
  input  logic      reqChan,
  input  logic      shadowPtr,
  input  logic      resValid,
  input  logic      resReady,
  output logic      reqReady,
  output logic      busy,
  output logic      csN,
  output logic      sclk,
  output hostStrb_t strb
);

  localparam int FRAME_CLKS = ACQ_CLKS + 1 + DATA_W;
  localparam int CNT_MAX    = (CLK_DIV > CS_HIGH_MIN) ? CLK_DIV : CS_HIGH_MIN;
  localparam int CNT_W      = $clog2(CNT_MAX + 1);
  localparam int BIT_W      = $clog2(FRAME_CLKS + 1);
  localparam logic [CNT_W-1:0] DIV_LAST = CNT_W'(CLK_DIV - 1);
  localparam logic [CNT_W-1:0] HI_LAST  = CNT_W'(CS_HIGH_MIN - 1);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(FRAME_CLKS);

  hostState_t state;
  logic [CNT_W-1:0] cnt;
  logic [BIT_W-1:0] bitCnt;
  logic dummyPend;
  logic hiDone, divDone;

  assign hiDone  = (cnt == HI_LAST);
  assign divDone = (cnt == DIV_LAST);

  assign reqReady = (state == ST_IDLE);
  assign busy     = (state != ST_IDLE);

  always_comb begin
    strb            = '0;
    strb.dummyFall  = (state == ST_CSHI) && hiDone && dummyPend;
    strb.frameStart = (state == ST_CSHI) && hiDone && !dummyPend;
    strb.sampleBit  = (state == ST_LOW) && divDone;
    strb.frameEnd   = (state == ST_HIGH) && divDone && (bitCnt == BIT_LAST);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      bitCnt    <= '0;
      dummyPend <= 1'b0;
      csN       <= 1'b1;
      sclk      <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (reqValid) begin
            dummyPend <= (reqChan != shadowPtr);
            cnt       <= '0;
            state     <= ST_CSHI;
          end
        end
        ST_CSHI: begin
          if (hiDone) begin
            cnt    <= '0;
            csN    <= 1'b0;
            bitCnt <= '0;
            state  <= dummyPend ? ST_DUMLO : ST_LOW;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_DUMLO: begin
          if (divDone) begin
            cnt       <= '0;
            csN       <= 1'b1;
            dummyPend <= 1'b0;
            state     <= ST_CSHI;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_LOW: begin
          if (divDone) begin
            cnt    <= '0;
            sclk   <= 1'b1;
            bitCnt <= bitCnt + 1'b1;
            state  <= ST_HIGH;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_HIGH: begin
          if (divDone) begin
            cnt  <= '0;
            sclk <= 1'b0;
            if (bitCnt == BIT_LAST) begin
              csN   <= 1'b1;
              state <= ST_DONE;
            end else begin
              state <= ST_LOW;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_DONE: begin
          if (resValid && resReady) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/adc_host_dp.sv
`timescale 1ns/1ps
module adc_host_dp
  import adc_host_pkg::*;
#(
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  hostStrb_t         strb,
  input  logic              sdi,
  input  logic              resReady,
  output logic              shadowPtr,
  output logic              resValid,
  output logic [DATA_W-1:0] resData,
  output logic              resChan,
  output logic              resMismatch
);

  localparam int SH_W = DATA_W + 1;

  logic [SH_W-1:0] shReg;
  logic            expChan;
  logic            idBit;

  assign idBit = shReg[SH_W-1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shadowPtr   <= 1'b0;
      expChan     <= 1'b0;
      shReg       <= '0;
      resValid    <= 1'b0;
      resData     <= '0;
      resChan     <= 1'b0;
      resMismatch <= 1'b0;
    end else begin
      if (strb.dummyFall) shadowPtr <= ~shadowPtr;
      if (strb.frameStart) begin
        expChan   <= shadowPtr;
        shadowPtr <= ~shadowPtr;
        shReg     <= '0;
      end
      if (strb.sampleBit) shReg <= {shReg[SH_W-2:0], sdi};
      if (strb.frameEnd) begin
        resValid    <= 1'b1;
        resData     <= shReg[DATA_W-1:0];
        resChan     <= idBit;
        resMismatch <= (idBit != expChan);
        if (idBit != expChan) shadowPtr <= ~idBit;
      end else if (resValid && resReady) begin
        resValid <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/adc_alt_host.sv
`timescale 1ns/1ps
module adc_alt_host
  import adc_host_pkg::*;
#(
  parameter int DATA_W      = 12,
  parameter int ACQ_CLKS    = 2,
  parameter int CLK_DIV     = 4,
  parameter int CS_HIGH_MIN = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqChan,
  output logic              reqReady,
  output logic              adcCsN,
  output logic              adcSclk,
  input  logic              adcSdo,
  output logic              resValid,
  input  logic              resReady,
  output logic [DATA_W-1:0] resData,
  output logic              resChan,
  output logic              resMismatch,
  output logic              busy
);

  hostStrb_t strb;
  logic      shadowPtr;

  adc_host_ctrl #(
    .DATA_W(DATA_W), .ACQ_CLKS(ACQ_CLKS),
    .CLK_DIV(CLK_DIV), .CS_HIGH_MIN(CS_HIGH_MIN)
  ) u_ctrl (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqChan(reqChan),
    .shadowPtr(shadowPtr),
    .resValid(resValid), .resReady(resReady),
    .reqReady(reqReady), .busy(busy),
    .csN(adcCsN), .sclk(adcSclk),
    .strb(strb)
  );

  adc_host_dp #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN),
    .strb(strb), .sdi(adcSdo), .resReady(resReady),
    .shadowPtr(shadowPtr),
    .resValid(resValid), .resData(resData),
    .resChan(resChan), .resMismatch(resMismatch)
  );

endmodule

// File: rtl/adc_alt_host_chk.sv
`timescale 1ns/1ps
module adc_alt_host_chk #(
  parameter int DATA_W      = 12,
  parameter int ACQ_CLKS    = 2,
  parameter int CLK_DIV     = 4,
  parameter int CS_HIGH_MIN = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqReady,
  input logic              adcCsN,
  input logic              adcSclk,
  input logic              resValid,
  input logic              resReady,
  input logic [DATA_W-1:0] resData,
  input logic              resChan,
  input logic              resMismatch,
  input logic              busy
);

  localparam int FRAME_CLKS = ACQ_CLKS + 1 + DATA_W;

  logic        csPrev, sclkPrev;
  logic [15:0] hiCnt;
  logic [15:0] riseCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      csPrev   <= 1'b1;
      sclkPrev <= 1'b0;
      hiCnt    <= '0;
      riseCnt  <= '0;
    end else begin
      csPrev   <= adcCsN;
      sclkPrev <= adcSclk;
      if (adcCsN) hiCnt <= (hiCnt == 16'hFFFF) ? hiCnt : hiCnt + 1'b1;
      else        hiCnt <= '0;
      if (csPrev && !adcCsN)                        riseCnt <= '0;
      else if (!adcCsN && adcSclk && !sclkPrev)     riseCnt <= riseCnt + 1'b1;
    end
  end

  assert_idle_cs_high_R1: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> (adcCsN && !adcSclk && !resValid));

  assert_cs_high_min_R4: assert property (@(posedge clk) disable iff (!rstN)
    (csPrev && !adcCsN) |-> (hiCnt >= 16'(CS_HIGH_MIN)));

  assert_frame_clocks_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!csPrev && adcCsN) |-> (riseCnt == 16'd0 || riseCnt == 16'(FRAME_CLKS)));

  assert_sclk_in_frame_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(adcSclk) |-> !adcCsN);

  assert_cs_rise_sclk_low_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(adcCsN) |-> !adcSclk);

  assert_result_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && !resReady) |=> (resValid && $stable(resData) &&
                                 $stable(resChan) && $stable(resMismatch)));

  assert_accept_busy_R10: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> (busy && !reqReady));

endmodule

bind adc_alt_host adc_alt_host_chk #(
  .DATA_W(DATA_W), .ACQ_CLKS(ACQ_CLKS),
  .CLK_DIV(CLK_DIV), .CS_HIGH_MIN(CS_HIGH_MIN)
) u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
  .adcCsN(adcCsN), .adcSclk(adcSclk), .resValid(resValid),
  .resReady(resReady), .resData(resData), .resChan(resChan),
  .resMismatch(resMismatch), .busy(busy)
);

// File: tb/tb_adc_alt_host.sv
`timescale 1ns/1ps
module tb_adc_alt_host;

  localparam int CLK_P = 10;
  localparam int DW    = 12;
  localparam int ACQ   = 2;
  localparam int DIV   = 2;
  localparam int HIMIN = 3;
  localparam int FRAME = ACQ + 1 + DW;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, reqChan = 1'b0, resReady = 1'b0;
  logic reqReady, adcCsN, adcSclk, resValid, resChan, resMismatch, busy;
  logic adcSdo = 1'b0;
  logic [DW-1:0] resData;

  int nTests = 0, nFail = 0;

  always #(CLK_P/2) clk = ~clk;

  adc_alt_host #(.DATA_W(DW), .ACQ_CLKS(ACQ), .CLK_DIV(DIV), .CS_HIGH_MIN(HIMIN)) dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqChan(reqChan),
    .reqReady(reqReady), .adcCsN(adcCsN), .adcSclk(adcSclk), .adcSdo(adcSdo),
    .resValid(resValid), .resReady(resReady), .resData(resData),
    .resChan(resChan), .resMismatch(resMismatch), .busy(busy)
  );

  // Behavioural converter: pointer flips on every chip-select fall.
  logic          modelPtr = 1'b0;
  logic          curChan = 1'b0;
  int            bitIdx = 0;
  logic [DW-1:0] sampleVal = '0;

  function automatic logic bitAt(int n);
    if (n <= ACQ) return 1'b0;
    if (n == ACQ + 1) return curChan;
    if (n <= ACQ + 1 + DW) return sampleVal[DW - 1 - (n - ACQ - 2)];
    return 1'b0;
  endfunction

  always @(negedge adcCsN) begin
    curChan  = modelPtr;
    modelPtr = ~modelPtr;
    bitIdx   = 1;
    adcSdo   = bitAt(1);
  end

  always @(negedge adcSclk) begin
    if (!adcCsN) begin
      bitIdx = bitIdx + 1;
      adcSdo = bitAt(bitIdx);
    end
  end

  // Port monitors
  int  csFalls = 0, sclkRises = 0, frameRises = 0, periodErr = 0, hiErr = 0;
  time lastRise = 0, csRiseT = 0;

  always @(posedge adcCsN) csRiseT = $time;
  always @(negedge adcCsN) begin
    csFalls    = csFalls + 1;
    frameRises = 0;
    if (($time - csRiseT) < HIMIN * CLK_P) hiErr = hiErr + 1;
  end
  always @(posedge adcSclk) begin
    if (adcCsN) periodErr = periodErr + 1;
    if (frameRises > 0 && ($time - lastRise) != 2 * DIV * CLK_P) periodErr = periodErr + 1;
    lastRise   = $time;
    frameRises = frameRises + 1;
    sclkRises  = sclkRises + 1;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // One request, end to end. intrude offers a second request mid-frame.
  task automatic doReq(input logic ch, input logic [DW-1:0] val, input int expFalls,
                       input logic expChan, input logic expMm, input int hold,
                       input bit intrude, input string reqTag);
    int f0, r0, n;
    sampleVal = val;
    f0 = csFalls;
    r0 = sclkRises;
    @(negedge clk);
    check(reqReady == 1'b1, "R9", "reqReady before request", int'(reqReady), 1);
    reqValid = 1'b1;
    reqChan  = ch;
    @(negedge clk);
    reqValid = 1'b0;
    check(busy == 1'b1 && reqReady == 1'b0, "R10", "busy after accept",
          int'(busy), 1);
    n = 0;
    while (!resValid && n < 3000) begin
      @(negedge clk);
      n++;
      if (intrude && n == 10) begin
        reqValid = 1'b1;
        reqChan  = ~ch;
      end else if (intrude && n == 11) begin
        reqValid = 1'b0;
      end
    end
    reqValid = 1'b0;
    check(resValid == 1'b1, "R9", "result arrives", int'(resValid), 1);
    check(resData == val, "R6", "data MSB first", int'(resData), int'(val));
    check(resChan == expChan, "R7", "channel tag", int'(resChan), int'(expChan));
    check(resMismatch == expMm, "R7", "mismatch flag", int'(resMismatch), int'(expMm));
    check(csFalls - f0 == expFalls, reqTag, "chip-select falls", csFalls - f0, expFalls);
    check(sclkRises - r0 == FRAME, "R5", "sclk rises per request", sclkRises - r0, FRAME);
    check(periodErr == 0, "R5", "sclk spacing and cs low", periodErr, 0);
    check(hiErr == 0, "R4", "cs high time", hiErr, 0);
    repeat (hold) @(negedge clk);
    check(resValid == 1'b1 && resData == val, "R9", "held until ready",
          int'(resValid), 1);
    check(busy == 1'b1, "R10", "busy while result waits", int'(busy), 1);
    resReady = 1'b1;
    @(negedge clk);
    resReady = 1'b0;
    check(resValid == 1'b0 && reqReady == 1'b1, "R9", "popped and idle",
          int'(resValid), 0);
    if (intrude) begin
      f0 = csFalls;
      repeat (20) @(negedge clk);
      check(csFalls == f0 && reqReady == 1'b1, "R10", "ignored request started nothing",
            csFalls - f0, 0);
    end
  endtask

  task automatic testReset();
    @(negedge clk);
    check(adcCsN == 1'b1 && adcSclk == 1'b0, "R1", "cs high sclk low", int'(adcCsN), 1);
    check(resValid == 1'b0 && busy == 1'b0, "R1", "no result, not busy", int'(resValid), 0);
    check(reqReady == 1'b1, "R1", "ready after reset", int'(reqReady), 1);
  endtask

  task automatic testAlternate();
    doReq(1'b0, 12'hA5C, 1, 1'b0, 1'b0, 3, 1'b0, "R1");
    doReq(1'b1, 12'h3F1, 1, 1'b1, 1'b0, 0, 1'b0, "R2");
    doReq(1'b0, 12'h801, 1, 1'b0, 1'b0, 1, 1'b0, "R2");
  endtask

  task automatic testRepeat();
    doReq(1'b0, 12'h001, 2, 1'b0, 1'b0, 2, 1'b0, "R3");
    doReq(1'b0, 12'hFFE, 2, 1'b0, 1'b0, 0, 1'b0, "R3");
  endtask

  task automatic testDesync();
    // pointer now 1 on both sides; a stray flip moves only the model to 0
    modelPtr = ~modelPtr;
    doReq(1'b1, 12'h5A5, 1, 1'b0, 1'b1, 2, 1'b0, "R7");
    // shadow realigned to 1: no dummy toggle expected
    doReq(1'b1, 12'h7E8, 1, 1'b1, 1'b0, 0, 1'b0, "R8");
  endtask

  task automatic testBusyIgnore();
    doReq(1'b0, 12'hC33, 1, 1'b0, 1'b0, 4, 1'b1, "R10");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testAlternate();
    testRepeat();
    testDesync();
    testBusyIgnore();
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule